// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Tracker

This block keeps the single reservation that a level-one cache holds for a load-linked / store-conditional pair. It watches three kinds of local event: a load-linked completing, a store-conditional arriving, and a plain store. It also watches coherence requests from other agents that would move a line out of the Exclusive or Modified state. From these events it keeps a link flag and the reserved line address. It returns a pass or fail result for every store-conditional.

Other agents could keep taking the line away between the load-linked and its store-conditional, and then neither would ever succeed. To prevent this, the tracker holds off downgrade requests that hit the reserved line for a fixed number of cycles after the load-linked. The hold also ends early when the matching store-conditional arrives. Downgrade requests for any other line always pass at once. Once the hold has ended, a downgrade of the reserved line goes through and removes the reservation. The coherence engine and the data arrays sit outside this block. The engine reports whether the line is Exclusive or Modified when the load-linked completes, and it honours the stall output.

Top module: `llsc_reservation_tracker`

## Requirements
- R1: After reset, `link_valid`, `sc_done`, `sc_ok` and `dg_stall` are all 0.
- R2: A load-linked with `ll_excl`=1 sets `link_valid` to 1 and `link_addr` to `ll_addr` on the next clock edge. A load-linked with `ll_excl`=0 leaves `link_valid` at 0.
- R3: A store-conditional raises `sc_done` for exactly one cycle after the edge that takes it in. In that cycle, `sc_ok` is 1 only if the link was set and `sc_addr` equals the reserved address.
- R4: A store-conditional clears the link whether it passes or fails.
- R5: A plain store to the reserved line clears the link. A store to any other line leaves the link unchanged.
- R6: While `dg_req` targets the reserved line, `dg_stall` is 1 combinationally during the HOLD_CYCLES cycles after the load-linked edge (16 by default) and is 0 from then on.
- R7: A downgrade of the reserved line that is not stalled clears the link on the next edge.
- R8: A downgrade of a line other than the reserved one is never stalled and does not change the link.
- R9: A new load-linked replaces the reservation, including its address, and restarts the hold window.
- R10: Once a store-conditional has been taken in, a downgrade of the formerly reserved line is no longer stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ll_valid | input | 1 | A load-linked completes this cycle |
| ll_addr | input | ADDR_W | Line address of the load-linked |
| ll_excl | input | 1 | The line is Exclusive or Modified when the load-linked completes |
| sc_valid | input | 1 | A store-conditional is presented |
| sc_addr | input | ADDR_W | Line address of the store-conditional |
| st_valid | input | 1 | A plain local store is written |
| st_addr | input | ADDR_W | Line address of the plain store |
| dg_req | input | 1 | Coherence request to downgrade a line out of Exclusive or Modified |
| dg_addr | input | ADDR_W | Line address of the downgrade request |
| dg_stall | output | 1 | Hold the downgrade request this cycle |
| sc_done | output | 1 | A store-conditional result is valid |
| sc_ok | output | 1 | The store-conditional passed |
| link_valid | output | 1 | A reservation is held |
| link_addr | output | ADDR_W | Reserved line address |

## Verification
The hold window is checked with a downgrade held on the reserved line across every cycle of the window. This shows both that each of the 16 cycles stalls and that the first cycle after the window does not stall and drops the reservation. Store-conditionals are tried with a matching address, a different address, and no link at all, which separates address comparison from link state. Plain stores and downgrades are each sent to another line and then to the reserved line, which shows that matching is done on the address. A second load-linked issued partway through a window is followed by a check at a point where only a restarted counter could still stall. A store-conditional arriving inside the window shows that the window ends early.

// File: rtl/llsc_reservation_tracker.sv
module llsc_reservation_tracker #(
  parameter int ADDR_W      = 26,
  parameter int HOLD_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ll_valid,
  input  logic [ADDR_W-1:0] ll_addr,
  input  logic              ll_excl,
  input  logic              sc_valid,
  input  logic [ADDR_W-1:0] sc_addr,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              dg_req,
  input  logic [ADDR_W-1:0] dg_addr,
  output logic              dg_stall,
  output logic              sc_done,
  output logic              sc_ok,
  output logic              link_valid,
  output logic [ADDR_W-1:0] link_addr
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_CYCLES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic              link_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q, ok_q;

  wire sc_hit  = link_q && (sc_addr == addr_q);
  wire st_hit  = link_q && (st_addr == addr_q);
  wire dg_hit  = link_q && (dg_addr == addr_q);
  wire holding = (cnt_q != '0);
  wire dg_take = dg_req && dg_hit && !holding;

  assign dg_stall   = dg_req && dg_hit && holding;
  assign sc_done    = done_q;
  assign sc_ok      = ok_q;
  assign link_valid = link_q;
  assign link_addr  = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_q <= 1'b0;
      addr_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      done_q <= sc_valid;
      ok_q   <= sc_valid && sc_hit;
      if (ll_valid) begin
        link_q <= ll_excl;
        addr_q <= ll_addr;
        cnt_q  <= ll_excl ? CNT_LOAD : '0;
      end else if (sc_valid || (st_valid && st_hit) || dg_take) begin
        link_q <= 1'b0;
        cnt_q  <= '0;
      end else if (holding) begin
        cnt_q  <= cnt_q - CNT_ONE;
      end
    end
  end

  AST_STALL_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    dg_stall |-> link_q); // R6
  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LOAD); // R6
  AST_LL_SETS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (ll_valid && ll_excl) |=> (link_q && addr_q == $past(ll_addr))); // R2
  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sc_ok |-> sc_done); // R3
  AST_SC_DROPS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid && !ll_valid) |=> !link_q); // R4
  AST_STORE_DROPS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && link_q && st_addr == addr_q && !ll_valid) |=> !link_q); // R5
  AST_OTHER_LINE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (dg_req && dg_addr != addr_q) |-> !dg_stall); // R8
  AST_SC_ENDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid && !ll_valid) |=> !dg_stall); // R10
endmodule

// File: tb/llsc_reservation_tracker_tb_top.sv
module llsc_reservation_tracker_tb_top;
  localparam int AW = 26;
  localparam int HOLD = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ll_valid = 0, ll_excl = 0, sc_valid = 0, st_valid = 0, dg_req = 0;
  logic [AW-1:0] ll_addr = '0, sc_addr = '0, st_addr = '0, dg_addr = '0;
  logic dg_stall, sc_done, sc_ok, link_valid;
  logic [AW-1:0] link_addr;
  int checks = 0;
  int errors = 0;

  localparam logic [AW-1:0] LA = 26'h0001234;
  localparam logic [AW-1:0] LB = 26'h00abcd0;
  localparam logic [AW-1:0] LC = 26'h3f00001;

  always #5 clk = ~clk;

  llsc_reservation_tracker #(.ADDR_W(AW), .HOLD_CYCLES(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .ll_valid(ll_valid), .ll_addr(ll_addr), .ll_excl(ll_excl),
    .sc_valid(sc_valid), .sc_addr(sc_addr),
    .st_valid(st_valid), .st_addr(st_addr),
    .dg_req(dg_req), .dg_addr(dg_addr),
    .dg_stall(dg_stall), .sc_done(sc_done), .sc_ok(sc_ok),
    .link_valid(link_valid), .link_addr(link_addr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    ll_valid = 0; ll_excl = 0; sc_valid = 0; st_valid = 0; dg_req = 0;
  endtask

  task automatic do_ll(input logic [AW-1:0] a, input logic e);
    ll_valid = 1; ll_addr = a; ll_excl = e;
    tick();
    idle();
  endtask

  task automatic do_sc(input logic [AW-1:0] a);
    sc_valid = 1; sc_addr = a;
    tick();
    idle();
  endtask

  task automatic settle();
    repeat (HOLD + 2) tick();
    do_sc(LC);
    tick();
  endtask

  task automatic t_reset();
    chk("R1 link_valid", link_valid, 0);
    chk("R1 sc_done", sc_done, 0);
    chk("R1 sc_ok", sc_ok, 0);
    dg_req = 1; dg_addr = '0; #1;
    chk("R1 dg_stall", dg_stall, 0);
    idle();
  endtask

  task automatic t_ll_sc_pass();
    do_ll(LA, 1);
    chk("R2 link set", link_valid, 1);
    chk("R2 link addr", link_addr, LA);
    do_sc(LA);
    chk("R3 done", sc_done, 1);
    chk("R3 pass", sc_ok, 1);
    chk("R4 link cleared after pass", link_valid, 0);
    tick();
    chk("R3 done one cycle", sc_done, 0);
  endtask

  task automatic t_sc_fail();
    do_ll(LA, 1);
    do_sc(LB);
    chk("R3 wrong addr done", sc_done, 1);
    chk("R3 wrong addr fails", sc_ok, 0);
    chk("R4 link cleared after fail", link_valid, 0);
    do_sc(LA);
    chk("R3 no link fails", sc_ok, 0);
    do_ll(LB, 0);
    chk("R2 non-exclusive no link", link_valid, 0);
    do_sc(LB);
    chk("R3 non-exclusive sc fails", sc_ok, 0);
  endtask

  task automatic t_store();
    do_ll(LA, 1);
    st_valid = 1; st_addr = LC;
    tick(); idle();
    chk("R5 other-line store keeps link", link_valid, 1);
    st_valid = 1; st_addr = LA;
    tick(); idle();
    chk("R5 same-line store clears link", link_valid, 0);
    tick();
  endtask

  task automatic t_window();
    do_ll(LA, 1);
    for (int i = 0; i < HOLD; i++) begin
      dg_req = 1; dg_addr = LA; #1;
      chk("R6 stall inside window", dg_stall, 1);
      tick();
    end
    chk("R6 link kept while stalled", link_valid, 1);
    dg_req = 1; dg_addr = LA; #1;
    chk("R6 no stall after window", dg_stall, 0);
    tick(); idle();
    chk("R7 accepted downgrade clears link", link_valid, 0);
  endtask

  task automatic t_other_line();
    do_ll(LA, 1);
    dg_req = 1; dg_addr = LC; #1;
    chk("R8 other line not stalled", dg_stall, 0);
    tick(); idle();
    chk("R8 link kept", link_valid, 1);
    settle();
  endtask

  task automatic t_relink();
    do_ll(LA, 1);
    repeat (10) tick();
    do_ll(LB, 1);
    chk("R9 new addr", link_addr, LB);
    dg_req = 1; dg_addr = LA; #1;
    chk("R9 old line free", dg_stall, 0);
    idle();
    repeat (10) tick();
    dg_req = 1; dg_addr = LB; #1;
    chk("R9 window restarted", dg_stall, 1);
    idle();
    settle();
  endtask

  task automatic t_sc_ends();
    do_ll(LA, 1);
    tick();
    do_sc(LA);
    chk("R10 sc passes in window", sc_ok, 1);
    dg_req = 1; dg_addr = LA; #1;
    chk("R10 no stall after sc", dg_stall, 0);
    idle();
    tick();
  endtask

  initial begin
    @(negedge clk);
    repeat (2) tick();
    rst_n = 1;
    t_reset();
    t_ll_sc_pass();
    t_sc_fail();
    t_store();
    t_window();
    t_other_line();
    t_relink();
    t_sc_ends();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule